// File: doc/BRIEF.md
# NAND Flash Command and Data Front End

This block sits between a register-style CPU bus and an 8- or 16-bit NAND flash device. Software writes command bytes, address bytes, data words and read requests into a small ordered write buffer. A strobe engine drains the buffer one entry at a time. Each entry becomes one bus cycle on the flash pins, with the latch-enable line that matches the entry's kind. The write and read strobe lengths come from a configuration register.

Reads take two phases. A write to the read-request offset, whose data is ignored, queues one device read. When the engine has captured the word, a sticky interrupt-status bit is set and the word can be collected from a read-data offset. The device ready/busy pin is synchronised, and its busy-to-ready transition sets another sticky status bit. A page-control offset starts a whole-page read or write. During a page transfer, words stream out of or into the block on a side port with one pulse per word, so a transfer engine outside this block can move the data. All status bits are cleared by writing ones. A mask register gates them onto a single interrupt line.

Top module: `nand_frontend`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are high, nf_cle, nf_ale and irq are low, and the status (offset 1), interrupt status (offset 2) and configuration (offset 0) registers read zero.
- R2: A write to offset 4 (command) produces one nf_we_n low pulse with nf_cle high and nf_ale low. A write to offset 5 (address) produces one pulse with nf_ale high and nf_cle low. A write to offset 6 (data) produces one pulse with both low. nf_dout carries the written value during the pulse.
- R3: Configuration bits [9:6] hold the write delay and bits [5:2] hold the read delay. nf_we_n stays low for write delay + 1 cycles and nf_re_n stays low for read delay + 1 cycles. Back-to-back buffer entries are separated by exactly one cycle with both strobes high.
- R4: The write buffer holds 4 entries and drains in arrival order. Status bit 0 reads 1 while it is full. A write to offsets 4 to 7 while the buffer is full is discarded.
- R5: nf_ce_n is low whenever a strobe is low. It stays low across consecutive entries and is high when the block is idle. Status bit 1 reads 1 while any work is queued or in progress.
- R6: A write to offset 7 starts exactly one nf_re_n pulse whatever data is written. The captured nf_din word is then readable at offset 8, and interrupt-status bit 1 is set.
- R7: Interrupt-status bits stay set until a one is written to them at offset 2. Writing zeros leaves them unchanged.
- R8: Interrupt-status bit 0 is set when the synchronised nf_rdy rises from 0 to 1. It is not set when nf_rdy falls.
- R9: Configuration bit 1 selects a 16-bit bus. In 8-bit mode, nf_dout bits [15:8] are zero and the captured read word has bits [15:8] cleared. In 16-bit mode, all 16 bits pass through.
- R10: Writing 1 to offset 9 reads a whole page, and writing 2 writes a whole page. Other values are ignored. Configuration bit 0 selects 512 bytes instead of 256. The word count is the byte count divided by the bus width in bytes. Each page read word appears on pg_rdata with a one-cycle pg_rvalid. Each page write word is taken from pg_wdata in the cycle pg_wtake is high. Page reads do not set interrupt-status bit 1. Interrupt-status bit 2 is set when the page ends.
- R11: irq is high exactly when some interrupt-status bit is set and its bit in the mask register (offset 3) is set.
- R12: nf_cle and nf_ale are never high together, and nf_we_n and nf_re_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset for writes and reads |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr |
| irq | output | 1 | Masked interrupt request |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_doe | output | 1 | Data bus output enable |
| nf_dout | output | 16 | Data driven to the flash |
| nf_din | input | 16 | Data from the flash |
| nf_rdy | input | 1 | Flash ready (1) / busy (0) |
| pg_wdata | input | 16 | Page write word source |
| pg_wtake | output | 1 | pg_wdata is consumed this cycle |
| pg_rdata | output | 16 | Page read word |
| pg_rvalid | output | 1 | pg_rdata valid for one cycle |

## Verification
A wrong buffer pointer or count shows at the pins within one entry's strobe time, as a repeated, lost or reordered latch cycle, or as a full flag that disagrees with how many writes were accepted. A wrong delay counter shows as a strobe that is one cycle too long or too short, or as a missing one-cycle gap between entries. A wrong capture or status path shows as a read-ready or page-done bit that is set late, not set, or not cleared. It can also show as a page that delivers the wrong number of words, which is visible when the page ends.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

  // Entry kind: the two low address bits of offsets 4..7 select it, so the order matters.
  typedef enum logic [1:0] {
    TAG_CMD   = 2'd0,
    TAG_ADDR  = 2'd1,
    TAG_DATA  = 2'd2,
    TAG_RDREQ = 2'd3
  } nfe_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2
  } nfe_state_e;

  localparam int unsigned OFF_CFG    = 0;
  localparam int unsigned OFF_STAT   = 1;
  localparam int unsigned OFF_IRQ    = 2;
  localparam int unsigned OFF_MASK   = 3;
  localparam int unsigned OFF_QBASE  = 4;
  localparam int unsigned OFF_RDDATA = 8;
  localparam int unsigned OFF_PAGE   = 9;

  localparam int unsigned IRQ_W      = 3;
  localparam int unsigned IRQ_NBUSY  = 0;
  localparam int unsigned IRQ_RDRDY  = 1;
  localparam int unsigned IRQ_PGDONE = 2;

endpackage

// File: rtl/nfe_sync.sv
module nfe_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/nfe_wbuf.sv
module nfe_wbuf #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && valid;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end
endmodule

// File: rtl/nfe_engine.sv
module nfe_engine
  import nfe_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned DLYW     = 4,
  parameter int unsigned PG_SMALL = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide,
  input  logic            page512,
  input  logic [DLYW-1:0] rd_dly,
  input  logic [DLYW-1:0] wr_dly,
  input  logic            fifo_valid,
  input  nfe_tag_e        fifo_tag,
  input  logic [DW-1:0]   fifo_data,
  output logic            fifo_pop,
  input  logic            pg_req,
  input  logic            pg_rd,
  output logic            pg_ack,
  output logic            pg_run,
  input  logic [DW-1:0]   pg_wdata,
  output logic            pg_wtake,
  output logic [DW-1:0]   pg_rdata,
  output logic            pg_rvalid,
  output logic            pg_done,
  output logic            rd_cap,
  output logic [DW-1:0]   rd_data,
  output logic            active,
  input  logic [DW-1:0]   nf_din,
  output logic            nf_ce_n,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we_n,
  output logic            nf_re_n,
  output logic            nf_doe,
  output logic [DW-1:0]   nf_dout
);
  localparam int unsigned PG_LARGE = 2 * PG_SMALL;
  localparam int unsigned CNTW     = $clog2(PG_LARGE);

  nfe_state_e      st_q, st_d;
  nfe_tag_e        tag_q, tag_d;
  logic [DW-1:0]   dat_q, dat_d;
  logic [DLYW-1:0] cnt_q, cnt_d;
  logic [CNTW-1:0] left_q, left_d;
  logic            inpg_q, inpg_d, pgrd_q, pgrd_d;
  logic            cap, launch;
  logic [CNTW-1:0] words_m1;
  logic [DW-1:0]   din_fit;
  logic [DW-1:0]   rd_data_q, pg_rdata_q;
  logic            pg_rvalid_q;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] v, input logic w16);
    fit = w16 ? v : (v & DW'(8'hFF));
  endfunction

  assign words_m1 = CNTW'(((page512 ? PG_LARGE : PG_SMALL) >> wide) - 1);
  assign din_fit  = fit(nf_din, wide);

  always_comb begin
    st_d     = st_q;
    tag_d    = tag_q;
    dat_d    = dat_q;
    cnt_d    = cnt_q;
    left_d   = left_q;
    inpg_d   = inpg_q;
    pgrd_d   = pgrd_q;
    cap      = 1'b0;
    launch   = 1'b0;
    fifo_pop = 1'b0;
    pg_ack   = 1'b0;
    pg_wtake = 1'b0;
    pg_done  = 1'b0;
    unique case (st_q)
      ST_IDLE: launch = 1'b1;
      ST_STROBE: begin
        if (cnt_q == '0) begin
          st_d = ST_HOLD;
          cap  = (tag_q == TAG_RDREQ);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (inpg_q && left_q != '0) begin
          left_d   = left_q - 1'b1;
          tag_d    = pgrd_q ? TAG_RDREQ : TAG_DATA;
          dat_d    = pg_wdata;
          pg_wtake = !pgrd_q;
          cnt_d    = pgrd_q ? rd_dly : wr_dly;
          st_d     = ST_STROBE;
        end else begin
          pg_done = inpg_q;
          inpg_d  = 1'b0;
          launch  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (launch) begin
      if (fifo_valid) begin
        fifo_pop = 1'b1;
        tag_d    = fifo_tag;
        dat_d    = fifo_data;
        cnt_d    = (fifo_tag == TAG_RDREQ) ? rd_dly : wr_dly;
        inpg_d   = 1'b0;
        st_d     = ST_STROBE;
      end else if (pg_req) begin
        pg_ack   = 1'b1;
        inpg_d   = 1'b1;
        pgrd_d   = pg_rd;
        left_d   = words_m1;
        tag_d    = pg_rd ? TAG_RDREQ : TAG_DATA;
        dat_d    = pg_wdata;
        pg_wtake = !pg_rd;
        cnt_d    = pg_rd ? rd_dly : wr_dly;
        st_d     = ST_STROBE;
      end else begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      tag_q       <= TAG_CMD;
      dat_q       <= '0;
      cnt_q       <= '0;
      left_q      <= '0;
      inpg_q      <= 1'b0;
      pgrd_q      <= 1'b0;
      rd_data_q   <= '0;
      pg_rdata_q  <= '0;
      pg_rvalid_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      tag_q       <= tag_d;
      dat_q       <= dat_d;
      cnt_q       <= cnt_d;
      left_q      <= left_d;
      inpg_q      <= inpg_d;
      pgrd_q      <= pgrd_d;
      pg_rvalid_q <= cap && inpg_q;
      if (cap && !inpg_q) rd_data_q  <= din_fit;
      if (cap && inpg_q)  pg_rdata_q <= din_fit;
    end
  end

  assign rd_cap    = cap && !inpg_q;
  assign rd_data   = rd_data_q;
  assign pg_rdata  = pg_rdata_q;
  assign pg_rvalid = pg_rvalid_q;
  assign pg_run    = inpg_q;
  assign active    = (st_q != ST_IDLE);
  assign nf_ce_n   = !active;
  assign nf_cle    = active && (tag_q == TAG_CMD);
  assign nf_ale    = active && (tag_q == TAG_ADDR);
  assign nf_we_n   = !((st_q == ST_STROBE) && (tag_q != TAG_RDREQ));
  assign nf_re_n   = !((st_q == ST_STROBE) && (tag_q == TAG_RDREQ));
  assign nf_doe    = active && (tag_q != TAG_RDREQ);
  assign nf_dout   = fit(dat_q, wide);
endmodule

// File: rtl/nand_frontend.sv
module nand_frontend
  import nfe_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 4,
  parameter int unsigned DLYW     = 4,
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned PG_SMALL = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          nf_ce_n,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic          nf_doe,
  output logic [DW-1:0] nf_dout,
  input  logic [DW-1:0] nf_din,
  input  logic          nf_rdy,
  input  logic [DW-1:0] pg_wdata,
  output logic          pg_wtake,
  output logic [DW-1:0] pg_rdata,
  output logic          pg_rvalid
);
  localparam int unsigned CFGW = 2 + 2 * DLYW;
  localparam int unsigned EW   = 2 + DW;

  logic             rst_int_n, rdy_s, rdy_prev_q, rdy_prev_d;
  logic [CFGW-1:0]  cfg_q, cfg_d;
  logic [IRQ_W-1:0] mask_q, mask_d, irq_q, irq_d, irq_set, irq_clr;
  logic             pend_q, pend_d, dir_q, dir_d;
  logic             wr_cfg, wr_irq, wr_mask, wr_page, push;
  logic [EW-1:0]    q_din, q_dout;
  logic             q_valid, q_full, q_pop;
  logic             pg_ack, pg_run, pg_done, rd_cap, active;
  logic [DW-1:0]    rd_data;

  nfe_sync #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n));

  nfe_sync #(.RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_int_n), .d(nf_rdy), .q(rdy_s));

  assign wr_cfg  = bus_we && (bus_addr == AW'(OFF_CFG));
  assign wr_irq  = bus_we && (bus_addr == AW'(OFF_IRQ));
  assign wr_mask = bus_we && (bus_addr == AW'(OFF_MASK));
  assign wr_page = bus_we && (bus_addr == AW'(OFF_PAGE));
  assign push    = bus_we && (bus_addr >= AW'(OFF_QBASE)) && (bus_addr <= AW'(OFF_QBASE + 3));
  assign q_din   = {bus_addr[1:0], bus_wdata};

  nfe_wbuf #(.W(EW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_int_n), .push(push), .din(q_din),
    .pop(q_pop), .dout(q_dout), .valid(q_valid), .full(q_full));

  nfe_engine #(.DW(DW), .DLYW(DLYW), .PG_SMALL(PG_SMALL)) u_engine (
    .clk(clk), .rst_n(rst_int_n),
    .wide(cfg_q[1]), .page512(cfg_q[0]),
    .rd_dly(cfg_q[2 +: DLYW]), .wr_dly(cfg_q[2 + DLYW +: DLYW]),
    .fifo_valid(q_valid), .fifo_tag(nfe_tag_e'(q_dout[EW-1 -: 2])),
    .fifo_data(q_dout[DW-1:0]), .fifo_pop(q_pop),
    .pg_req(pend_q), .pg_rd(dir_q), .pg_ack(pg_ack), .pg_run(pg_run),
    .pg_wdata(pg_wdata), .pg_wtake(pg_wtake), .pg_rdata(pg_rdata),
    .pg_rvalid(pg_rvalid), .pg_done(pg_done),
    .rd_cap(rd_cap), .rd_data(rd_data), .active(active),
    .nf_din(nf_din), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_doe(nf_doe), .nf_dout(nf_dout));

  always_comb begin
    irq_set                 = '0;
    irq_set[IRQ_NBUSY]      = rdy_s && !rdy_prev_q;
    irq_set[IRQ_RDRDY]      = rd_cap;
    irq_set[IRQ_PGDONE]     = pg_done;
    irq_clr                 = wr_irq ? bus_wdata[IRQ_W-1:0] : '0;
    irq_d                   = (irq_q & ~irq_clr) | irq_set;
    cfg_d                   = wr_cfg ? bus_wdata[CFGW-1:0] : cfg_q;
    mask_d                  = wr_mask ? bus_wdata[IRQ_W-1:0] : mask_q;
    rdy_prev_d              = rdy_s;
    pend_d                  = pend_q && !pg_ack;
    dir_d                   = dir_q;
    if (wr_page && !pend_q && !pg_run) begin
      if (bus_wdata == DW'(1)) begin
        pend_d = 1'b1;
        dir_d  = 1'b1;
      end else if (bus_wdata == DW'(2)) begin
        pend_d = 1'b1;
        dir_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q      <= '0;
      mask_q     <= '0;
      irq_q      <= '0;
      rdy_prev_q <= 1'b1;
      pend_q     <= 1'b0;
      dir_q      <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      mask_q     <= mask_d;
      irq_q      <= irq_d;
      rdy_prev_q <= rdy_prev_d;
      pend_q     <= pend_d;
      dir_q      <= dir_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(OFF_CFG):    bus_rdata = DW'(cfg_q);
      AW'(OFF_STAT):   bus_rdata = DW'({active || q_valid || pend_q, q_full});
      AW'(OFF_IRQ):    bus_rdata = DW'(irq_q);
      AW'(OFF_MASK):   bus_rdata = DW'(mask_q);
      AW'(OFF_RDDATA): bus_rdata = rd_data;
      default:         bus_rdata = '0;
    endcase
  end

  assign irq = |(irq_q & mask_q);
endmodule

// File: rtl/nand_frontend_chk.sv
module nand_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_rdy,
  input logic [2:0] irq_q
);
  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  // R5
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  // R6
  rdready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q[1]) |-> $past(!nf_re_n));

  // R8
  nbusy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q[0]) |-> $past(nf_rdy, 3));
endmodule

bind nand_frontend nand_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
  .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
  .nf_rdy(nf_rdy), .irq_q(irq_q));

// File: tb/nand_frontend_tb.sv
`timescale 1ns/1ps
module nand_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_doe;
  logic [15:0] nf_dout, nf_din, pg_wdata, pg_rdata;
  logic        nf_rdy = 1'b1;
  logic        pg_wtake, pg_rvalid;

  int n_chk = 0;
  int n_bad = 0;

  // device model state and monitor log
  int rd_idx = 0;
  int take_cnt = 0;
  bit take_pend = 0;
  logic [15:0] ev_dat [2048];
  bit          ev_rd  [2048];
  bit          ev_cle [2048];
  bit          ev_ale [2048];
  int          ev_len [2048];
  int          ev_gap [2048];
  int ev_n = 0;
  logic [15:0] rv_dat [1024];
  int rv_n = 0;
  int ce_bad = 0;
  int lo_len = 0, hi_cnt = 0, cur_gap = 0;
  bit we_p = 1, re_p = 1, l_cle = 0, l_ale = 0;
  logic [15:0] l_dat = '0;

  always #10 clk = ~clk;

  function automatic logic [15:0] dev_word(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'h5A ^ b, b + 8'h11};
  endfunction

  function automatic logic [15:0] fit(input logic [15:0] v, input bit w16);
    return w16 ? v : {8'h00, v[7:0]};
  endfunction

  function automatic logic [15:0] mkcfg(input bit p512, input bit w16, input int rdd, input int wrd);
    logic [3:0] r, w;
    r = rdd[3:0];
    w = wrd[3:0];
    return {6'b0, w, r, w16, p512};
  endfunction

  assign nf_din   = dev_word(rd_idx);
  assign pg_wdata = 16'h1000 + take_cnt[15:0];

  nand_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_doe(nf_doe), .nf_dout(nf_dout), .nf_din(nf_din),
    .nf_rdy(nf_rdy), .pg_wdata(pg_wdata), .pg_wtake(pg_wtake),
    .pg_rdata(pg_rdata), .pg_rvalid(pg_rvalid));

  always @(negedge clk) begin
    if (take_pend) take_cnt <= take_cnt + 1;
    take_pend <= pg_wtake;
    if (nf_ce_n && (!nf_we_n || !nf_re_n)) ce_bad <= ce_bad + 1;
    if (pg_rvalid && rv_n < 1024) begin
      rv_dat[rv_n] <= pg_rdata;
      rv_n <= rv_n + 1;
    end
    if (nf_we_n && nf_re_n) begin
      if ((!we_p || !re_p) && ev_n < 2048) begin
        ev_dat[ev_n] <= l_dat;
        ev_rd[ev_n]  <= !re_p;
        ev_cle[ev_n] <= l_cle;
        ev_ale[ev_n] <= l_ale;
        ev_len[ev_n] <= lo_len;
        ev_gap[ev_n] <= cur_gap;
        ev_n <= ev_n + 1;
        if (!re_p) rd_idx <= rd_idx + 1;
        hi_cnt <= 1;
      end else begin
        hi_cnt <= hi_cnt + 1;
      end
      lo_len <= 0;
    end else begin
      if (we_p && re_p) begin
        cur_gap <= hi_cnt;
        lo_len <= 1;
      end else begin
        lo_len <= lo_len + 1;
      end
      l_cle <= nf_cle;
      l_ale <= nf_ale;
      l_dat <= nf_dout;
    end
    we_p <= nf_we_n;
    re_p <= nf_re_n;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1;
    bus_addr = a[3:0];
    bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a[3:0];
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(1, s);
      if (!s[1]) begin
        repeat (2) @(negedge clk);
        return;
      end
    end
    chk(0, "R5 idle timeout", 32'(s), 0);
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int b, mis;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !irq, "R1 pins",
        {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 6'b111000);
    bus_rd(1, v); chk(v == 0, "R1 status", v, 0);
    bus_rd(2, v); chk(v == 0, "R1 irq status", v, 0);
    bus_rd(0, v); chk(v == 0, "R1 config", v, 0);

    // R4 burst: 8-bit, write delay 5; sixth entry hits a full buffer
    bus_wr(0, mkcfg(0, 0, 1, 5));
    b = ev_n;
    bus_wr(4, 16'h01F0);
    bus_wr(5, 16'h0012);
    bus_wr(5, 16'h0034);
    bus_wr(5, 16'h0056);
    bus_wr(6, 16'h00AB);
    bus_rd(1, v); chk(v[0] == 1'b1, "R4 full flag", v, 1);
    chk(v[1] == 1'b1, "R5 busy flag", v, 2);
    bus_wr(6, 16'h00CD);
    wait_idle();
    chk(ev_n - b == 5, "R4 full write dropped", ev_n - b, 5);
    chk(ev_cle[b] && !ev_ale[b] && ev_dat[b] == 16'h00F0, "R2 R9 command cycle",
        {ev_cle[b], ev_ale[b], ev_dat[b]}, {2'b10, 16'h00F0});
    chk(!ev_cle[b+1] && ev_ale[b+1] && ev_dat[b+1] == 16'h0012, "R2 R4 address order",
        ev_dat[b+1], 16'h0012);
    chk(ev_dat[b+2] == 16'h0034 && ev_dat[b+3] == 16'h0056, "R4 order",
        {ev_dat[b+2], ev_dat[b+3]}, 32'h00340056);
    chk(!ev_cle[b+4] && !ev_ale[b+4] && ev_dat[b+4] == 16'h00AB, "R2 R4 data last",
        ev_dat[b+4], 16'h00AB);
    mis = 0;
    for (int i = 0; i < 5; i++) begin
      if (ev_len[b+i] != 6) mis++;
      if (i > 0 && ev_gap[b+i] != 1) mis++;
    end
    chk(mis == 0, "R3 strobe width and gap", mis, 0);
    chk(ce_bad == 0 && nf_ce_n, "R5 chip enable", ce_bad, 0);
    bus_rd(1, v); chk(v == 0, "R4 R5 status after drain", v, 0);

    // R2 R3 R9 random single cycles
    for (int it = 0; it < 24; it++) begin
      int tg, wd;
      bit w16;
      logic [15:0] val;
      tg  = $urandom % 3;
      wd  = $urandom % 4;
      w16 = 1'($urandom % 2);
      val = 16'($urandom);
      bus_wr(0, mkcfg(0, w16, 0, wd));
      b = ev_n;
      bus_wr(4 + tg, val);
      wait_idle();
      chk(ev_n - b == 1 && !ev_rd[b] && ev_dat[b] == fit(val, w16), "R2 R9 random data",
          ev_dat[b], fit(val, w16));
      chk(ev_cle[b] == (tg == 0) && ev_ale[b] == (tg == 1), "R2 random latch",
          {ev_cle[b], ev_ale[b]}, {tg == 0, tg == 1});
      chk(ev_len[b] == wd + 1, "R3 random width", ev_len[b], wd + 1);
    end

    // R6 read request, 8-bit, read delay 2, written data ignored
    bus_wr(0, mkcfg(0, 0, 2, 0));
    b = ev_n;
    mis = rd_idx;
    bus_wr(7, 16'hFFFF);
    wait_idle();
    chk(ev_n - b == 1 && ev_rd[b], "R6 one read pulse", ev_n - b, 1);
    chk(ev_len[b] == 3, "R3 read width", ev_len[b], 3);
    bus_rd(8, v); chk(v == fit(dev_word(mis), 0), "R6 R9 read data 8-bit", v, fit(dev_word(mis), 0));
    bus_rd(2, v); chk(v == 16'h0002, "R6 ready bit", v, 2);

    // R7 write-one-to-clear
    bus_wr(2, 16'h0000);
    bus_rd(2, v); chk(v == 16'h0002, "R7 zero write keeps", v, 2);
    bus_wr(2, 16'h0002);
    bus_rd(2, v); chk(v == 16'h0000, "R7 one write clears", v, 0);

    // R9 16-bit read and write
    bus_wr(0, mkcfg(0, 1, 0, 1));
    mis = rd_idx;
    bus_wr(7, 16'h0000);
    wait_idle();
    bus_rd(8, v); chk(v == dev_word(mis), "R9 read data 16-bit", v, dev_word(mis));
    b = ev_n;
    bus_wr(6, 16'hBEEF);
    wait_idle();
    chk(ev_dat[b] == 16'hBEEF, "R9 write data 16-bit", ev_dat[b], 16'hBEEF);
    bus_wr(2, 16'h0007);

    // R8 ready/busy tracking
    @(negedge clk) nf_rdy = 1'b0;
    repeat (6) @(negedge clk);
    bus_rd(2, v); chk(v[0] == 1'b0, "R8 falling edge no set", v, 0);
    nf_rdy = 1'b1;
    @(negedge clk);
    chk(u_dut.bus_rdata == 16'h0 || bus_addr != 2, "R8 not early", bus_rdata, 0);
    repeat (4) @(negedge clk);
    bus_rd(2, v); chk(v[0] == 1'b1, "R8 rising edge sets", v, 1);

    // R11 mask
    bus_rd(2, v);
    chk(irq == 1'b0, "R11 masked off", irq, 0);
    bus_wr(3, 16'h0002);
    #1 chk(irq == 1'b0, "R11 other bit masked", irq, 0);
    bus_wr(3, 16'h0001);
    #1 chk(irq == 1'b1, "R11 enabled bit", irq, 1);
    bus_wr(2, 16'h0001);
    #1 chk(irq == 1'b0, "R11 cleared", irq, 0);
    bus_wr(3, 16'h0000);

    // R10 page read: 512 bytes, 8-bit => 512 words
    bus_wr(0, mkcfg(1, 0, 0, 0));
    b = rv_n;
    mis = rd_idx;
    bus_wr(9, 16'h0001);
    wait_idle();
    chk(rv_n - b == 512, "R10 page read word count", rv_n - b, 512);
    begin
      int bad_w = 0;
      for (int j = 0; j < 512 && b + j < 1024; j++)
        if (rv_dat[b+j] != fit(dev_word(mis + j), 0)) bad_w++;
      chk(bad_w == 0, "R10 page read data", bad_w, 0);
    end
    bus_rd(2, v); chk(v == 16'h0004, "R10 page done only", v, 4);
    bus_wr(2, 16'h0004);

    // R10 page write: 256 bytes, 16-bit => 128 words
    bus_wr(0, mkcfg(0, 1, 0, 0));
    b = ev_n;
    mis = take_cnt;
    bus_wr(9, 16'h0002);
    wait_idle();
    chk(ev_n - b == 128, "R10 page write word count", ev_n - b, 128);
    begin
      int bad_w = 0;
      for (int j = 0; j < 128; j++)
        if (ev_rd[b+j] || ev_cle[b+j] || ev_ale[b+j] || ev_len[b+j] != 1 ||
            ev_dat[b+j] != 16'h1000 + 16'(mis + j)) bad_w++;
      chk(bad_w == 0, "R10 page write data", bad_w, 0);
    end
    bus_rd(2, v); chk(v[2] == 1'b1, "R10 page write done", v, 4);
    bus_wr(2, 16'h0004);

    // R10 other page value ignored
    b = ev_n;
    bus_wr(9, 16'h0003);
    repeat (20) @(negedge clk);
    bus_rd(1, v);
    chk(ev_n == b && v == 0, "R10 value 3 ignored", ev_n - b, 0);
    chk(ce_bad == 0, "R5 chip enable overall", ce_bad, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule